// File: doc/BRIEF.md
# Thread Interrupt Presenter Register Window

This block keeps the operating-system interrupt context of one hardware thread. Software reaches it through a byte-addressed register window on a simple single-cycle bus. Each access carries an address, a size code, a read/write flag and write data. Read data is returned combinationally in the same cycle. The block holds four pieces of state:

- a status byte whose bit 7 is the exception flag;
- the current processor priority (CPPR);
- an eight-bit pending buffer with one bit per priority;
- a derived pending priority (PIPR).

The block raises one interrupt line while the exception flag is set.

Software uses the window in three ways:

- Plain ring accesses read the context and change CPPR.
- A special set-pending write posts a priority into the pending buffer.
- A special 2-byte acknowledge read takes the highest pending priority, makes it the new CPPR and clears its pending bit. The same read returns the old status and the new CPPR.

Address layout:

- The ring occupies window offsets 0x10 to 0x1F: status at 0x10, CPPR at 0x11, pending buffer at 0x12, PIPR at 0x17. All other ring bytes read as zero.
- Offsets at or above 0x800 form the special region: acknowledge at 0x810, set-pending at 0x818.

Top module: `tipTop`

## Requirements
- R1: After reset CPPR is 0xFF, the pending buffer is 0, the status byte is 0, PIPR reads 0xFF and irqOut is low.
- R2: A 1-byte write (size code 0) at 0x818 sets pending bit (7 - p), where p is the low write-data byte, if p < 8. A p of 8 or more leaves the buffer unchanged.
- R3: PIPR, readable at 0x17, is 7 minus the position of the most significant set pending bit. It is 0xFF when the buffer is empty.
- R4: On the clock edge after a cycle in which PIPR < CPPR, status bit 7 and irqOut become 1. They stay 1 until an acknowledge read.
- R5: A 2-byte read (size code 1) at 0x810 returns the status byte before the update in bits 15:8. It returns the CPPR after the update in bits 7:0, with bits 63:16 zero. After the next edge irqOut and status bit 7 are 0.
- R6: If status bit 7 is set, an acknowledge loads CPPR from PIPR and clears the pending bit of that priority. If it is clear, CPPR and the pending buffer do not change.
- R7: A 1-byte write at 0x11 stores the low data byte into CPPR if it is 7 or less, and 0xFF otherwise.
- R8: Aligned 4-byte (size code 2) and 8-byte (size code 3) writes at 0x10 load CPPR from data lane 1 (bits 15:8), with the same clamp as R7, and change no other byte. 2-byte writes, misaligned writes and 1-byte writes to other ring bytes change nothing.
- R9: A ring read of 2^s bytes (size code s) at an address aligned to that size returns ring byte (offset + i) in lane i (bits 8i+7:8i). Unused upper lanes are zero. A misaligned ring read returns all ones.
- R10: In the special region, an access at the wrong offset or with the wrong size changes no state, and a read there returns all ones.
- R11: An access below 0x800 outside 0x10 to 0x1F changes no state, and a read there returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Window byte offset |
| busSize | input | 2 | log2 of the access size in bytes |
| busWdata | input | 64 | Write data, byte lane i in bits 8i+7:8i |
| busRdata | output | 64 | Read data for the current read; 0 when no read is present |
| irqOut | output | 1 | Interrupt request to the thread |

## Verification
Pending priorities are posted one, two and several at a time, both above and below the current CPPR. This separates a correct most-significant-bit encoder from one that picks the lowest bit, and separates a strict comparison from a non-strict one.

Acknowledge is issued both with the exception flag set and with it clear. This shows whether the CPPR promotion and the pending-bit clearing are gated by the flag, and whether the returned status is the value from before the update.

CPPR is written with all legal access sizes and alignments and with values on both sides of 7. Each data lane carries a distinct value, so a write from the wrong lane or a missing clamp shows up in the CPPR read back.

Reads are made at every size, with and without alignment, inside the ring, outside it and in the special region. This tells lane ordering, upper-lane zeroing and the all-ones error response apart.

// File: rtl/tipPkg.sv
package tipPkg;
  localparam int PRI_COUNT = 8;
  localparam logic [7:0] MAX_PRI = 8'(PRI_COUNT - 1);
  localparam logic [7:0] NO_PRI = 8'hFF;

  typedef enum logic [1:0] {SZ1 = 2'd0, SZ2 = 2'd1, SZ4 = 2'd2, SZ8 = 2'd3} accSize_e;

  typedef struct packed {
    logic       rdEn;
    logic       ringRd;
    logic       ackRd;
    logic       setPend;
    logic       cpprWr;
    logic [2:0] cpprLane;
    logic [3:0] rdOff;
    logic [1:0] rdSize;
  } ctrlStb_t;

  function automatic logic [7:0] priToBit(input logic [7:0] pri);
    return (pri < 8'(PRI_COUNT)) ? (8'h80 >> pri[2:0]) : 8'h00;
  endfunction
endpackage

// File: rtl/tipCtrl.sv
module tipCtrl
  import tipPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RING_BASE = 12'h010,
  parameter logic [ADDR_W-1:0] SPC_BASE  = 12'h800,
  parameter logic [ADDR_W-1:0] ACK_OFF   = 12'h810,
  parameter logic [ADDR_W-1:0] PEND_OFF  = 12'h818
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output ctrlStb_t          stb
);
  logic [3:0] ringOff;
  logic [3:0] sizeBytes;
  logic       aligned;
  logic       isSpc;
  logic       isRing;
  logic       rdReq;
  logic       wrReq;
  logic       wideWr;

  always_comb begin
    ringOff   = busAddr[3:0];
    sizeBytes = 4'd1 << busSize;
    aligned   = (busAddr[2:0] & 3'(sizeBytes - 4'd1)) == 3'd0;
    isSpc     = busAddr >= SPC_BASE;
    isRing    = !isSpc && (busAddr[ADDR_W-1:4] == RING_BASE[ADDR_W-1:4]);
    rdReq     = busValid && !busWrite;
    wrReq     = busValid && busWrite;
    wideWr    = (busSize == SZ4 || busSize == SZ8) && aligned && ringOff == 4'd0;

    stb          = '0;
    stb.rdEn     = rdReq;
    stb.ringRd   = rdReq && isRing && aligned;
    stb.ackRd    = rdReq && isSpc && busAddr == ACK_OFF && busSize == SZ2;
    stb.setPend  = wrReq && isSpc && busAddr == PEND_OFF && busSize == SZ1;
    stb.cpprWr   = wrReq && isRing &&
                   ((busSize == SZ1 && ringOff == 4'd1) || wideWr);
    stb.cpprLane = {2'b00, ~ringOff[0]};
    stb.rdOff    = ringOff;
    stb.rdSize   = busSize;
  end
endmodule

// File: rtl/tipDatapath.sv
module tipDatapath
  import tipPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStb_t    stb,
  input  logic [63:0] wdata,
  output logic [63:0] rdata,
  output logic        irqOut
);
  logic [7:0]  cpprQ;
  logic [7:0]  ipbQ;
  logic        excQ;
  logic [7:0]  pipr;
  logic [7:0]  laneByte;
  logic [7:0]  cpprIn;
  logic [7:0]  statusByte;
  logic [3:0]  sizeBytes;
  logic [63:0] laneShift;

  // Highest pending priority: the most significant set bit wins.
  always_comb begin
    pipr = NO_PRI;
    for (int i = 0; i < PRI_COUNT; i++) begin
      if (ipbQ[i]) pipr = 8'(PRI_COUNT - 1 - i);
    end
  end

  always_comb begin
    laneShift  = wdata >> {stb.cpprLane, 3'b000};
    laneByte   = laneShift[7:0];
    cpprIn     = (laneByte > MAX_PRI) ? NO_PRI : laneByte;
    statusByte = {excQ, 7'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpprQ <= NO_PRI;
      ipbQ  <= '0;
      excQ  <= 1'b0;
    end else begin
      if (stb.ackRd && excQ) begin
        cpprQ <= pipr;
        ipbQ  <= ipbQ & ~priToBit(pipr);
      end
      if (stb.setPend) ipbQ <= ipbQ | priToBit(wdata[7:0]);
      if (stb.cpprWr) cpprQ <= cpprIn;
      excQ <= stb.ackRd ? 1'b0 : (excQ || (pipr < cpprQ));
    end
  end

  assign irqOut = excQ;

  function automatic logic [7:0] ringByte(input logic [3:0] idx);
    case (idx)
      4'd0:    return statusByte;
      4'd1:    return cpprQ;
      4'd2:    return ipbQ;
      4'd7:    return pipr;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    sizeBytes = 4'd1 << stb.rdSize;
    rdata = '0;
    if (stb.ackRd) begin
      rdata[15:0] = {statusByte, excQ ? pipr : cpprQ};
    end else if (stb.ringRd) begin
      for (int i = 0; i < 8; i++) begin
        if (4'(i) < sizeBytes) rdata[8*i +: 8] = ringByte(stb.rdOff + 4'(i));
      end
    end else if (stb.rdEn) begin
      rdata = '1;
    end
  end
endmodule

// File: rtl/tipTop.sv
module tipTop
  import tipPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RING_BASE = 12'h010,
  parameter logic [ADDR_W-1:0] SPC_BASE  = 12'h800,
  parameter logic [ADDR_W-1:0] ACK_OFF   = 12'h810,
  parameter logic [ADDR_W-1:0] PEND_OFF  = 12'h818
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [63:0]       busWdata,
  output logic [63:0]       busRdata,
  output logic              irqOut
);
  ctrlStb_t stb;

  tipCtrl #(
    .ADDR_W(ADDR_W), .RING_BASE(RING_BASE), .SPC_BASE(SPC_BASE),
    .ACK_OFF(ACK_OFF), .PEND_OFF(PEND_OFF)
  ) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .stb(stb)
  );

  tipDatapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata),
    .rdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/tipChk.sv
module tipChk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RING_BASE = 12'h010,
  parameter logic [ADDR_W-1:0] SPC_BASE  = 12'h800,
  parameter logic [ADDR_W-1:0] ACK_OFF   = 12'h810,
  parameter logic [ADDR_W-1:0] PEND_OFF  = 12'h818
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [63:0]       busWdata,
  input logic [63:0]       busRdata,
  input logic              irqOut,
  input logic [7:0]        cpprQ,
  input logic [7:0]        ipbQ,
  input logic [7:0]        piprW
);
  logic ackReq;
  logic pendReq;
  logic cpprByteWr;
  logic spcOther;
  logic ringMisRd;

  assign ackReq     = busValid && !busWrite && busAddr == ACK_OFF && busSize == 2'd1;
  assign pendReq    = busValid && busWrite && busAddr == PEND_OFF && busSize == 2'd0;
  assign cpprByteWr = busValid && busWrite && busAddr == RING_BASE + 1 && busSize == 2'd0;
  assign spcOther   = busValid && busWrite && busAddr >= SPC_BASE && !pendReq;
  assign ringMisRd  = busValid && !busWrite && busAddr[ADDR_W-1:4] == RING_BASE[ADDR_W-1:4]
                      && busSize == 2'd2 && busAddr[1:0] != 2'd0;

  a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> !irqOut);

  a_r7_cppr_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (cpprByteWr && busWdata[7:0] > 8'd7) |=> cpprQ == 8'hFF);

  a_r2_set_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pendReq && busWdata[7:0] < 8'd8) |=> (ipbQ & (8'h80 >> $past(busWdata[2:0]))) != 8'h00);

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(piprW < cpprQ));

  a_r9_misaligned_ones: assert property (@(posedge clk) disable iff (!rstN)
    ringMisRd |-> busRdata == '1);

  a_r10_special_ignored: assert property (@(posedge clk) disable iff (!rstN)
    spcOther |=> ($stable(ipbQ) && $stable(cpprQ)));

  a_r3_pipr_empty: assert property (@(posedge clk) disable iff (!rstN)
    (ipbQ == 8'h00) == (piprW == 8'hFF));
endmodule

bind tipTop tipChk #(
  .ADDR_W(ADDR_W), .RING_BASE(RING_BASE), .SPC_BASE(SPC_BASE),
  .ACK_OFF(ACK_OFF), .PEND_OFF(PEND_OFF)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
  .busRdata(busRdata), .irqOut(irqOut),
  .cpprQ(u_dp.cpprQ), .ipbQ(u_dp.ipbQ), .piprW(u_dp.pipr)
);

// File: tb/tb_tipTop.sv
module tb_tipTop;
  localparam logic [11:0] ACK  = 12'h810;
  localparam logic [11:0] PEND = 12'h818;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busValid;
  logic        busWrite;
  logic [11:0] busAddr;
  logic [1:0]  busSize;
  logic [63:0] busWdata;
  logic [63:0] busRdata;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int mCppr;
  int mIpb;
  bit mExc;

  always #4 clk = ~clk;

  tipTop dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int modelPipr();
    for (int p = 0; p < 8; p++) if ((mIpb >> (7 - p)) & 1) return p;
    return 255;
  endfunction

  function automatic int bitOf(input int p);
    return (p < 8) ? (1 << (7 - p)) : 0;
  endfunction

  function automatic int modelByte(input int idx);
    case (idx)
      0: return mExc ? 128 : 0;
      1: return mCppr;
      2: return mIpb;
      7: return modelPipr();
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] expRead(input int a, input int sz);
    logic [63:0] r = '0;
    int n = 1 << sz;
    if (a >= 'h800) begin
      if (a == ACK && sz == 1) begin
        r[15:8] = 8'(modelByte(0));
        r[7:0]  = 8'(mExc ? modelPipr() : mCppr);
        return r;
      end
      return '1;
    end
    if (a < 'h10 || a > 'h1F) return '1;
    if (a % n != 0) return '1;
    for (int i = 0; i < n; i++) r[8*i +: 8] = 8'(modelByte(a - 'h10 + i));
    return r;
  endfunction

  task automatic step(input bit v, input bit wr, input int a, input int sz,
                      input logic [63:0] wd, input string req);
    int pp;
    int off;
    int n;
    int b;
    bit ack;
    bit nextExc;
    @(negedge clk);
    busValid = v; busWrite = wr; busAddr = 12'(a); busSize = 2'(sz); busWdata = wd;
    #2;
    if (v && !wr) check(busRdata == expRead(a, sz), req, busRdata, expRead(a, sz));
    if (!v) check(busRdata == 64'h0, req, busRdata, 64'h0);
    @(posedge clk);
    pp = modelPipr();
    ack = v && !wr && a == ACK && sz == 1;
    nextExc = ack ? 1'b0 : (mExc || pp < mCppr);
    if (ack && mExc) begin
      mCppr = pp;
      mIpb = mIpb & ~bitOf(pp);
    end
    if (v && wr && a == PEND && sz == 0) mIpb = mIpb | bitOf(int'(wd[7:0]));
    off = a - 'h10;
    n = 1 << sz;
    if (v && wr && a >= 'h10 && a <= 'h1F && sz != 1 && (a % n) == 0 && off <= 1 && off + n > 1) begin
      b = int'(8'(wd >> (8 * (1 - off))));
      mCppr = (b > 7) ? 255 : b;
    end
    mExc = nextExc;
    #1;
    check(irqOut == mExc, "R4", 64'(irqOut), 64'(mExc));
  endtask

  task automatic rd(input int a, input int sz, input string req);
    step(1, 0, a, sz, 64'h0, req);
  endtask

  task automatic wr(input int a, input int sz, input logic [63:0] wd, input string req);
    step(1, 1, a, sz, wd, req);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 64'h0, "R4");
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; busValid = 0; busWrite = 0; busAddr = '0; busSize = '0; busWdata = '0;
    mCppr = 255; mIpb = 0; mExc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(irqOut == 1'b0, "R1", 64'(irqOut), 64'h0);
    rd('h10, 3, "R1");
    check(busRdata == 64'hFF00_0000_0000_FF00, "R1", busRdata, 64'hFF00_0000_0000_FF00);

    // R2 / R3: post priorities
    wr(PEND, 0, 64'h3, "R2");
    rd('h12, 0, "R2");
    rd('h17, 0, "R3");
    idle();
    wr(PEND, 0, 64'h9, "R2");
    rd('h12, 0, "R2");
    wr(PEND, 1, 64'h0, "R10");
    rd('h12, 0, "R10");
    wr(PEND, 0, 64'h1, "R2");
    rd('h17, 0, "R3");
    rd('h10, 0, "R4");

    // R5 / R6: acknowledge with and without the exception flag
    rd(ACK, 1, "R5");
    rd('h10, 2, "R6");
    idle();
    rd(ACK, 1, "R6");
    rd('h10, 2, "R6");

    // R7: CPPR byte writes
    wr('h11, 0, 64'h20, "R7");
    rd('h11, 0, "R7");
    idle();
    wr('h11, 0, 64'h5, "R7");
    rd('h11, 0, "R7");
    rd(ACK, 1, "R5");
    idle();

    // R8: wide and ignored writes
    wr('h10, 2, 64'hAAAA_BBCC_0006_DD77, "R8");
    rd('h10, 3, "R8");
    wr('h10, 3, 64'h1111_2222_3333_0277, "R8");
    rd('h10, 3, "R8");
    wr('h10, 1, 64'h0000_0000_0000_0400, "R8");
    wr('h12, 2, 64'h0000_0000_0400_0400, "R8");
    wr('h14, 2, 64'h0000_0000_0000_0400, "R8");
    wr('h12, 0, 64'hFF, "R8");
    rd('h10, 3, "R8");
    wr('h10, 3, 64'h0000_0000_0000_0900, "R8");
    rd('h11, 0, "R8");

    // R9: read sizes and alignment
    rd('h10, 1, "R9");
    rd('h12, 1, "R9");
    rd('h14, 2, "R9");
    rd('h18, 3, "R9");
    rd('h16, 1, "R9");
    rd('h11, 1, "R9");
    rd('h12, 2, "R9");
    rd('h14, 3, "R9");

    // R11: outside the ring
    rd('h20, 0, "R11");
    rd('h00, 3, "R11");
    wr('h21, 0, 64'h1, "R11");
    wr('h01, 0, 64'h1, "R11");
    rd('h10, 3, "R11");

    // R10: special region misuse
    rd('h820, 1, "R10");
    rd(ACK, 2, "R10");
    rd(ACK, 0, "R10");
    rd(PEND, 0, "R10");
    wr(ACK, 1, 64'h2, "R10");
    wr('h830, 0, 64'h0, "R10");
    rd('h10, 3, "R10");

    // Drain remaining pending work
    wr(PEND, 0, 64'h0, "R2");
    idle();
    rd(ACK, 1, "R5");
    rd('h10, 3, "R6");
    idle();
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule